// File: doc/BRIEF.md
# Requester-to-Stream ID Translation Table

This block holds a small programmable table that turns the 16-bit requester ID of an inbound PCIe transaction into the stream ID an IOMMU uses to pick its translation context. Each slot is one 32-bit word with three fields: a valid flag, a stream ID and the requester ID it applies to. Software fills slots through a simple indexed write/read port. The datapath presents requester IDs on a lookup port and gets back the stream ID with a hit flag one clock later.

The table is fully associative. When more than one valid slot holds the same requester ID, the slot with the lowest index is used. A lookup that finds no valid slot raises a one-cycle mapping-error event. The depth is set by a parameter of at most 64. The index space always spans 64 slots. Slots at or above the built depth read as zero and drop writes, so software can find the real depth by writing a pattern and reading it back.

Top module: `reqid_stream_map`

## Requirements
- R1: A slot word has the valid flag in bit 31, the stream ID in bits 30:16 and the requester ID in bits 15:0. Within the requester ID, bits 15:8 are the bus, bits 7:3 the device and bits 2:0 the function.
- R2: A write to an implemented slot stores the whole word. A read of that slot raises `cfg_rvalid` on the next cycle, with the stored word on `cfg_rdata`.
- R3: Slots with index at or above `ENTRIES` read as zero and ignore writes. A word written there never produces a lookup hit.
- R4: Writing zero to a slot invalidates it, and lookups stop matching it.
- R5: One cycle after `lk_req`, `lk_valid` is high. `lk_hit` is high exactly when a valid slot holds `lk_rid`, and `lk_sid` then carries that slot's stream ID. Otherwise `lk_sid` is zero.
- R6: When several valid slots match, the lowest-index slot supplies the stream ID.
- R7: `lk_miss_evt` pulses for one cycle, together with `lk_valid`, when a lookup misses. It is never high without a lookup result.
- R8: After reset all slots read as zero and `cfg_rvalid`, `lk_valid`, `lk_hit` and `lk_miss_evt` are low.
- R9: A slot whose valid flag is clear never matches, even when its requester ID field equals the looked-up ID.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Slot write strobe |
| cfg_rd | input | 1 | Slot read strobe |
| cfg_idx | input | 6 | Slot index for the write or read |
| cfg_wdata | input | 32 | Slot word to write |
| cfg_rdata | output | 32 | Slot word read back |
| cfg_rvalid | output | 1 | Read data valid, one cycle after `cfg_rd` |
| lk_req | input | 1 | Lookup request |
| lk_rid | input | 16 | Requester ID to translate |
| lk_valid | output | 1 | Lookup result valid |
| lk_hit | output | 1 | A valid slot matched |
| lk_sid | output | 15 | Stream ID of the winning slot, zero on a miss |
| lk_miss_evt | output | 1 | Mapping-error event on a miss |

## Verification
The assertions check the following on every cycle:
- every request gets a result one cycle later;
- the miss event only appears with a missed result;
- a miss carries a zero stream ID;
- out-of-range reads return zero;
- the priority select never picks more than one slot.

The bench's scenarios cover what a per-cycle property cannot judge without a model of the table contents. That includes the right stream ID for a given requester ID and lowest-index priority among duplicates. It also includes invalidation by a zero write, valid-clear slots that never match, and writes above the depth leaving no trace. A behavioural model checks every output on every clock through a long random mix of writes, reads and lookups.

// File: rtl/reqid_map_pkg.sv
package reqid_map_pkg;
  localparam int SLOT_SPACE = 64;
  localparam int IDX_W      = $clog2(SLOT_SPACE);
  localparam int RID_W      = 16;
  localparam int SID_W      = 15;

  // bit 31 valid, 30:16 stream ID, 15:0 requester ID (bus/dev/fn)
  typedef struct packed {
    logic             vld;
    logic [SID_W-1:0] sid;
    logic [RID_W-1:0] rid;
  } map_slot_t;
endpackage

// File: rtl/map_slot_store.sv
module map_slot_store
  import reqid_map_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     wr_en,
  input  logic                     rd_en,
  input  logic [IDX_W-1:0]         idx,
  input  map_slot_t                wdata,
  output map_slot_t                rdata,
  output logic                     rvalid,
  output map_slot_t [ENTRIES-1:0]  slots
);
  localparam logic [IDX_W:0] DEPTH = (IDX_W+1)'(ENTRIES);

  logic      beyond;
  map_slot_t rd_word;
  map_slot_t rdata_q;
  logic      rvalid_q;

  assign beyond = ({1'b0, idx} >= DEPTH);

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    logic      sel;
    map_slot_t nxt;
    map_slot_t q;
    assign sel = wr_en && (idx == IDX_W'(i));
    always_comb begin
      nxt = q;
      if (sel) nxt = wdata;
    end
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)   q <= '0;
      else if (sel) q <= nxt;
    end
    assign slots[i] = q;
  end

  always_comb begin
    rd_word = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (idx == IDX_W'(i)) rd_word = slots[i];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= rd_en;
      if (rd_en) rdata_q <= rd_word;
    end
  end

  assign rdata  = rdata_q;
  assign rvalid = rvalid_q;

  a_r2_read_answers: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rvalid);
  a_r3_beyond_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && beyond) |=> (rdata == '0));
endmodule

// File: rtl/map_match_unit.sv
module map_match_unit
  import reqid_map_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  map_slot_t [ENTRIES-1:0]  slots,
  input  logic [RID_W-1:0]         rid,
  output logic                     hit,
  output logic [SID_W-1:0]         sid
);
  logic [ENTRIES-1:0] match;
  logic [ENTRIES-1:0] winner;
  logic [ENTRIES:0]   seen;

  assign seen[0] = 1'b0;

  for (genvar i = 0; i < ENTRIES; i++) begin : g_cmp
    assign match[i]   = slots[i].vld && (slots[i].rid == rid);
    assign winner[i]  = match[i] && !seen[i];
    assign seen[i+1]  = seen[i] || match[i];
  end

  always_comb begin
    sid = '0;
    for (int i = 0; i < ENTRIES; i++)
      if (winner[i]) sid = sid | slots[i].sid;
  end

  assign hit = seen[ENTRIES];

  // R6: the priority chain selects at most one slot
  a_r6_single_winner: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(winner));
endmodule

// File: rtl/map_result_stage.sv
module map_result_stage
  import reqid_map_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req,
  input  logic             hit_d,
  input  logic [SID_W-1:0] sid_d,
  output logic             valid,
  output logic             hit,
  output logic [SID_W-1:0] sid,
  output logic             miss_evt
);
  logic             valid_n, hit_n, miss_n;
  logic [SID_W-1:0] sid_n;
  logic             valid_q, hit_q, miss_q;
  logic [SID_W-1:0] sid_q;

  always_comb begin
    valid_n = req;
    hit_n   = req && hit_d;
    sid_n   = (req && hit_d) ? sid_d : '0;
    miss_n  = req && !hit_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      hit_q   <= 1'b0;
      sid_q   <= '0;
      miss_q  <= 1'b0;
    end else begin
      valid_q <= valid_n;
      hit_q   <= hit_n;
      sid_q   <= sid_n;
      miss_q  <= miss_n;
    end
  end

  assign valid    = valid_q;
  assign hit      = hit_q;
  assign sid      = sid_q;
  assign miss_evt = miss_q;

  a_r5_result_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
    req |=> valid);
endmodule

// File: rtl/reqid_stream_map.sv
module reqid_stream_map
  import reqid_map_pkg::*;
#(
  parameter int ENTRIES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic        cfg_rd,
  input  logic [5:0]  cfg_idx,
  input  logic [31:0] cfg_wdata,
  output logic [31:0] cfg_rdata,
  output logic        cfg_rvalid,
  input  logic        lk_req,
  input  logic [15:0] lk_rid,
  output logic        lk_valid,
  output logic        lk_hit,
  output logic [14:0] lk_sid,
  output logic        lk_miss_evt
);
  map_slot_t [ENTRIES-1:0] slots;
  map_slot_t               rd_word;
  logic                    hit_d;
  logic [SID_W-1:0]        sid_d;

  map_slot_store #(.ENTRIES(ENTRIES)) u_store (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (cfg_wr),
    .rd_en  (cfg_rd),
    .idx    (cfg_idx),
    .wdata  (map_slot_t'(cfg_wdata)),
    .rdata  (rd_word),
    .rvalid (cfg_rvalid),
    .slots  (slots)
  );

  map_match_unit #(.ENTRIES(ENTRIES)) u_match (
    .clk   (clk),
    .rst_n (rst_n),
    .slots (slots),
    .rid   (lk_rid),
    .hit   (hit_d),
    .sid   (sid_d)
  );

  map_result_stage u_result (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (lk_req),
    .hit_d    (hit_d),
    .sid_d    (sid_d),
    .valid    (lk_valid),
    .hit      (lk_hit),
    .sid      (lk_sid),
    .miss_evt (lk_miss_evt)
  );

  assign cfg_rdata = 32'(rd_word);

  a_r7_event_only_on_miss: assert property (@(posedge clk) disable iff (!rst_n)
    lk_miss_evt |-> (lk_valid && !lk_hit));
  a_r7_miss_raises_event: assert property (@(posedge clk) disable iff (!rst_n)
    (lk_valid && !lk_hit) |-> lk_miss_evt);
  a_r5_miss_sid_zero: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_hit |-> (lk_sid == '0));
endmodule

// File: tb/reqid_stream_map_test.sv
`timescale 1ns/1ps
module reqid_stream_map_test;
  localparam int ENTRIES = 16;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_wr, cfg_rd, lk_req;
  logic [5:0]  cfg_idx;
  logic [31:0] cfg_wdata;
  logic [15:0] lk_rid;
  logic [31:0] cfg_rdata;
  logic        cfg_rvalid, lk_valid, lk_hit, lk_miss_evt;
  logic [14:0] lk_sid;

  always #2.5 clk = ~clk;

  reqid_stream_map #(.ENTRIES(ENTRIES)) uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_rd(cfg_rd),
    .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
    .cfg_rvalid(cfg_rvalid), .lk_req(lk_req), .lk_rid(lk_rid),
    .lk_valid(lk_valid), .lk_hit(lk_hit), .lk_sid(lk_sid),
    .lk_miss_evt(lk_miss_evt)
  );

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  logic [31:0] mdl [64];
  logic        e_rv, e_lv, e_hit, e_err;
  logic [31:0] e_rd;
  logic [14:0] e_sid;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < 64; i++) mdl[i] = 32'h0;
      e_rv = 0; e_lv = 0; e_hit = 0; e_err = 0; e_rd = 0; e_sid = 0;
    end else begin
      e_rv = cfg_rd;
      if (cfg_rd) e_rd = (int'(cfg_idx) < ENTRIES) ? mdl[cfg_idx] : 32'h0;
      e_lv = lk_req; e_hit = 0; e_sid = 0;
      if (lk_req) begin
        for (int i = 0; i < ENTRIES; i++)
          if (!e_hit && mdl[i][31] && mdl[i][15:0] == lk_rid) begin
            e_hit = 1; e_sid = mdl[i][30:16];
          end
      end
      e_err = lk_req && !e_hit;
      if (cfg_wr && int'(cfg_idx) < ENTRIES) mdl[cfg_idx] = cfg_wdata;
    end
  end

  always @(negedge clk) begin
    if (rst_n && !done) begin
      chk(cfg_rvalid == e_rv, "R2 model rvalid", 32'(cfg_rvalid), 32'(e_rv));
      if (e_rv) chk(cfg_rdata == e_rd, "R2/R3 model rdata", cfg_rdata, e_rd);
      chk(lk_valid == e_lv, "R5 model lk_valid", 32'(lk_valid), 32'(e_lv));
      chk(lk_hit == e_hit, "R5 model lk_hit", 32'(lk_hit), 32'(e_hit));
      chk(lk_sid == e_sid, "R6 model lk_sid", 32'(lk_sid), 32'(e_sid));
      chk(lk_miss_evt == e_err, "R7 model miss_evt", 32'(lk_miss_evt), 32'(e_err));
    end
  end

  task automatic idle();
    cfg_wr = 0; cfg_rd = 0; lk_req = 0;
  endtask

  task automatic wr(input int idx, input logic [31:0] d);
    @(negedge clk);
    cfg_wr = 1; cfg_idx = 6'(idx); cfg_wdata = d;
    @(negedge clk);
    idle();
  endtask

  task automatic rd(input int idx, input logic [31:0] exp, input string tag);
    @(negedge clk);
    cfg_rd = 1; cfg_idx = 6'(idx);
    @(negedge clk);
    idle();
    chk(cfg_rvalid && cfg_rdata == exp, tag, cfg_rdata, exp);
  endtask

  task automatic look(input logic [15:0] rid, input bit ehit,
                      input logic [14:0] esid, input string tag);
    @(negedge clk);
    lk_req = 1; lk_rid = rid;
    @(negedge clk);
    idle();
    chk(lk_valid && lk_hit == ehit, tag, 32'(lk_hit), 32'(ehit));
    chk(lk_sid == esid, tag, 32'(lk_sid), 32'(esid));
    chk(lk_miss_evt == !ehit, {tag, " event"}, 32'(lk_miss_evt), 32'(!ehit));
    @(negedge clk);
    chk(!lk_miss_evt && !lk_valid, "R7 event one cycle", 32'(lk_miss_evt), 32'h0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 0; idle(); cfg_idx = 0; cfg_wdata = 0; lk_rid = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R8: quiet outputs and empty table after reset
    chk(!cfg_rvalid && !lk_valid && !lk_hit && !lk_miss_evt, "R8 outputs low",
        {28'h0, cfg_rvalid, lk_valid, lk_hit, lk_miss_evt}, 32'h0);
    rd(0, 32'h0, "R8 slot0 zero");
    rd(ENTRIES - 1, 32'h0, "R8 last slot zero");

    // R1/R2: bus 1, dev 1, fn 0 -> rid 0x0108, sid 0x123
    wr(0, 32'h8123_0108);
    rd(0, 32'h8123_0108, "R2 readback");
    look(16'((1 << 8) | (1 << 3) | 0), 1'b1, 15'h0123, "R1 field layout hit");

    // R6: duplicates, lowest index wins
    wr(5, 32'h8555_0210);
    wr(3, 32'h8AAA_0210);
    look(16'h0210, 1'b1, 15'h0AAA, "R6 lowest index");

    // R9: valid clear never matches
    wr(6, 32'h0777_0300);
    look(16'h0300, 1'b0, 15'h0, "R9 invalid slot miss");
    look(16'h7777, 1'b0, 15'h0, "R7 plain miss");

    // R3: beyond depth
    wr(ENTRIES, 32'h8001_0400);
    rd(ENTRIES, 32'h0, "R3 beyond reads zero");
    wr(63, 32'h000B_AD1D);
    rd(63, 32'h0, "R3 top slot reads zero");
    look(16'h0400, 1'b0, 15'h0, "R3 beyond write ignored");

    // R4: zero write invalidates
    wr(3, 32'h0);
    rd(3, 32'h0, "R4 zeroed slot");
    look(16'h0210, 1'b1, 15'h0555, "R4 next match after invalidate");

    // random mix compared against the model every clock
    for (int n = 0; n < 2000; n++) begin
      logic [15:0] pool [4];
      pool[0] = 16'h0108; pool[1] = 16'h0210; pool[2] = 16'h0300; pool[3] = 16'hFFFF;
      @(negedge clk);
      cfg_wr    = ($urandom_range(0, 3) == 0);
      cfg_rd    = ($urandom_range(0, 2) == 0);
      cfg_idx   = 6'($urandom_range(0, 23));
      cfg_wdata = {1'($urandom_range(0, 1)), 15'($urandom), pool[$urandom_range(0, 3)]};
      if ($urandom_range(0, 7) == 0) cfg_wdata = 32'h0;
      lk_req    = ($urandom_range(0, 1) == 1);
      lk_rid    = pool[$urandom_range(0, 3)];
    end
    @(negedge clk);
    idle();
    repeat (3) @(negedge clk);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule